// File: doc/BRIEF.md
# Transmit Timestamp Capture Register

This block records the time of day at the moment a transmit frame that asked for a timestamp passes its timestamp point in the MAC. The MAC gives a one-cycle event strobe, and with it a flag that says whether the frame wants a stamp. When capture is switched on and no earlier stamp is waiting, the block copies the live seconds and nanoseconds into a holding register on that same cycle. It then raises a pending flag. If the interrupt is unmasked, it also gives a one-cycle interrupt pulse.

The held stamp stays locked until software reads the high (seconds) word. That read is the only thing that clears the pending flag and lets the block take a new stamp. The low word has no side effect, so it can be read at any time. Requests that arrive while a stamp is pending are not captured, and a saturating counter records how many were lost. Turning capture off does not discard a stamp that is already pending. After software turns capture on, it reads the high word once to clear out any stale stamp.

Top module: `txts_capture`

## Requirements
- R1: After reset, `cap_valid`, `irq`, `drop_cnt`, `cap_hi` and `cap_lo` are all zero.
- R2: While `cap_en` is 0, a request (`tx_evt` and `tx_ts_req` both high) neither captures nor increments `drop_cnt`.
- R3: A request with `cap_en`=1 and `cap_valid`=0 copies `time_sec` into `cap_hi` and `time_ns` into `cap_lo`, using the values on the request cycle. `cap_valid` is 1 from the next cycle.
- R4: A `tx_evt` pulse without `tx_ts_req`, or `tx_ts_req` without `tx_evt`, has no effect.
- R5: While `cap_valid` is 1, an enabled request leaves `cap_hi` and `cap_lo` unchanged and adds one to `drop_cnt`.
- R6: A one-cycle `rd_hi` pulse while `cap_valid` is 1 clears `cap_valid` on the next cycle and keeps the held words. A later request is then captured. A `rd_hi` pulse while `cap_valid` is 0 changes nothing.
- R7: With `irq_en`=1, `irq` is high for exactly the one cycle in which `cap_valid` first reads 1 after a capture.
- R8: With `irq_en`=0 on the capture cycle, `irq` stays 0.
- R9: A request that arrives in the same cycle as a clearing `rd_hi` is dropped and counted. `cap_valid` then goes to 0 and the held words do not change.
- R10: `drop_cnt` saturates at its all-ones value (15 for DROP_W=4).
- R11: Taking `cap_en` to 0 while a stamp is pending keeps `cap_valid` and the held words. A `rd_hi` pulse then discards the stamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_sec | input | SEC_W | Live time, seconds part |
| time_ns | input | NS_W | Live time, nanoseconds part |
| tx_evt | input | 1 | One-cycle strobe: a frame's timestamp point is passing |
| tx_ts_req | input | 1 | The frame on `tx_evt` asks for a timestamp |
| cap_en | input | 1 | Capture enable |
| irq_en | input | 1 | Interrupt unmask |
| rd_hi | input | 1 | One-cycle strobe: software reads the high word |
| cap_lo | output | NS_W | Held nanoseconds word |
| cap_hi | output | SEC_W | Held seconds word |
| cap_valid | output | 1 | A stamp is pending |
| irq | output | 1 | One-cycle pulse when a stamp is taken and unmasked |
| drop_cnt | output | DROP_W | Saturating count of lost requests |

## Verification
The two functions that can fall on the same cycle are the clearing read of the high word and a new timestamp request. The bench provokes this by raising `rd_hi`, `tx_evt` and `tx_ts_req` together while a stamp is pending. It judges the outcome one cycle later. The correct outcome is that `cap_valid` has dropped, the held words still show the older stamp, and `drop_cnt` has gone up by one. A second, separate request after that cycle must then be captured.

// File: rtl/txts_pkg.sv
package txts_pkg;

    // Decision taken for the transmit event of the current cycle
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_TAKE = 2'd1,
        ACT_DROP = 2'd2
    } txts_act_e;

endpackage

// File: rtl/txts_gate.sv
module txts_gate
    import txts_pkg::*;
(
    input  logic      tx_evt,
    input  logic      tx_ts_req,
    input  logic      cap_en,
    input  logic      busy_q,
    output txts_act_e act
);

    logic want;

    always_comb begin
        want = tx_evt & tx_ts_req & cap_en;
        if (!want)
            act = ACT_IDLE;
        else if (busy_q)
            act = ACT_DROP;
        else
            act = ACT_TAKE;
    end

endmodule

// File: rtl/txts_sat_ctr.sv
module txts_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/txts_capture.sv
module txts_capture
    import txts_pkg::*;
#(
    parameter int SEC_W  = 32,
    parameter int NS_W   = 32,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  time_sec,
    input  logic [NS_W-1:0]   time_ns,
    input  logic              tx_evt,
    input  logic              tx_ts_req,
    input  logic              cap_en,
    input  logic              irq_en,
    input  logic              rd_hi,
    output logic [NS_W-1:0]   cap_lo,
    output logic [SEC_W-1:0]  cap_hi,
    output logic              cap_valid,
    output logic              irq,
    output logic [DROP_W-1:0] drop_cnt
);

    localparam int STAMP_W = SEC_W + NS_W;

    typedef struct packed {
        logic               valid;
        logic               irq;
        logic [STAMP_W-1:0] stamp;
    } cap_state_t;

    cap_state_t s_d, s_q;
    txts_act_e  act;

    txts_gate u_gate (
        .tx_evt    (tx_evt),
        .tx_ts_req (tx_ts_req),
        .cap_en    (cap_en),
        .busy_q    (s_q.valid),
        .act       (act)
    );

    txts_sat_ctr #(.W(DROP_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (act == ACT_DROP),
        .cnt   (drop_cnt)
    );

    // Next-state: capture wins only when idle; the high-word read releases the lock
    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (act == ACT_TAKE) begin
            s_d.stamp = {time_sec, time_ns};
            s_d.valid = 1'b1;
            s_d.irq   = irq_en;
        end else if (rd_hi) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign cap_hi    = s_q.stamp[STAMP_W-1:NS_W];
    assign cap_lo    = s_q.stamp[NS_W-1:0];
    assign cap_valid = s_q.valid;
    assign irq       = s_q.irq;

endmodule

// File: rtl/txts_capture_chk.sv
module txts_capture_chk #(
    parameter int SEC_W  = 32,
    parameter int NS_W   = 32,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEC_W-1:0]  time_sec,
    input logic [NS_W-1:0]   time_ns,
    input logic              tx_evt,
    input logic              tx_ts_req,
    input logic              cap_en,
    input logic              irq_en,
    input logic              rd_hi,
    input logic [NS_W-1:0]   cap_lo,
    input logic [SEC_W-1:0]  cap_hi,
    input logic              cap_valid,
    input logic              irq,
    input logic [DROP_W-1:0] drop_cnt
);

    localparam logic [DROP_W-1:0] DMAX = {DROP_W{1'b1}};

    logic req;
    assign req = tx_evt & tx_ts_req;

    p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !cap_valid) |=> !cap_valid);

    p_capture_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cap_en && !cap_valid) |=> (cap_valid && cap_hi == $past(time_sec) && cap_lo == $past(time_ns)));

    p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_valid) |-> $past(req && cap_en));

    p_hold_words_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> ($stable(cap_hi) && $stable(cap_lo)));

    p_drop_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && req && cap_en && drop_cnt != DMAX) |=> drop_cnt == $past(drop_cnt) + 1'b1);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && rd_hi) |=> !cap_valid);

    p_irq_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $rose(cap_valid));

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_valid) |-> (irq == $past(irq_en)));

    p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == DMAX) |=> drop_cnt == DMAX);

endmodule

bind txts_capture txts_capture_chk #(
    .SEC_W  (SEC_W),
    .NS_W   (NS_W),
    .DROP_W (DROP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_sec  (time_sec),
    .time_ns   (time_ns),
    .tx_evt    (tx_evt),
    .tx_ts_req (tx_ts_req),
    .cap_en    (cap_en),
    .irq_en    (irq_en),
    .rd_hi     (rd_hi),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .cap_valid (cap_valid),
    .irq       (irq),
    .drop_cnt  (drop_cnt)
);

// File: tb/tb_txts_capture.sv
module tb_txts_capture;

    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [31:0]   time_sec, time_ns;
    logic          tx_evt, tx_ts_req, cap_en, irq_en, rd_hi;
    logic [31:0]   cap_lo, cap_hi;
    logic          cap_valid, irq;
    logic [DW-1:0] drop_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    txts_capture #(.SEC_W(32), .NS_W(32), .DROP_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .time_sec(time_sec), .time_ns(time_ns),
        .tx_evt(tx_evt), .tx_ts_req(tx_ts_req), .cap_en(cap_en),
        .irq_en(irq_en), .rd_hi(rd_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
        .cap_valid(cap_valid), .irq(irq), .drop_cnt(drop_cnt)
    );

    typedef struct packed {
        logic        evt;
        logic        req;
        logic        en;
        logic        rdh;
        logic        ien;
        logic [31:0] sec;
        logic [31:0] ns;
        logic        e_valid;
        logic [31:0] e_hi;
        logic [31:0] e_lo;
        logic        e_irq;
        logic [3:0]  e_drop;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // R2: disabled request ignored, not counted
        '{1'b1,1'b1,1'b0,1'b0,1'b1, 32'h0000_0A0A, 32'h0000_0B0B, 1'b0, 32'h0, 32'h0, 1'b0, 4'd0, 8'd2},
        // R4: strobe without flag
        '{1'b1,1'b0,1'b1,1'b0,1'b1, 32'h0000_0C0C, 32'h0000_0D0D, 1'b0, 32'h0, 32'h0, 1'b0, 4'd0, 8'd4},
        // R4: flag without strobe
        '{1'b0,1'b1,1'b1,1'b0,1'b1, 32'h0000_0E0E, 32'h0000_0F0F, 1'b0, 32'h0, 32'h0, 1'b0, 4'd0, 8'd4},
        // R3 / R7: capture with interrupt
        '{1'b1,1'b1,1'b1,1'b0,1'b1, 32'h6512_0011, 32'h3B9A_0022, 1'b1, 32'h6512_0011, 32'h3B9A_0022, 1'b1, 4'd0, 8'd3},
        // R7: pulse lasts one cycle
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 32'h6512_0012, 32'h0000_0001, 1'b1, 32'h6512_0011, 32'h3B9A_0022, 1'b0, 4'd0, 8'd7},
        // R5: request while pending is dropped
        '{1'b1,1'b1,1'b1,1'b0,1'b1, 32'h0000_0033, 32'h0000_0044, 1'b1, 32'h6512_0011, 32'h3B9A_0022, 1'b0, 4'd1, 8'd5},
        // R5: idle keeps stamp
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 32'h0000_0034, 32'h0000_0045, 1'b1, 32'h6512_0011, 32'h3B9A_0022, 1'b0, 4'd1, 8'd5},
        // R9: clearing read and request together
        '{1'b1,1'b1,1'b1,1'b1,1'b1, 32'h0000_0055, 32'h0000_0066, 1'b0, 32'h6512_0011, 32'h3B9A_0022, 1'b0, 4'd2, 8'd9},
        // R6: stays clear
        '{1'b0,1'b0,1'b1,1'b0,1'b1, 32'h0000_0056, 32'h0000_0067, 1'b0, 32'h6512_0011, 32'h3B9A_0022, 1'b0, 4'd2, 8'd6},
        // R6 / R8: re-armed capture, interrupt masked
        '{1'b1,1'b1,1'b1,1'b0,1'b0, 32'h0000_0077, 32'h0000_0088, 1'b1, 32'h0000_0077, 32'h0000_0088, 1'b0, 4'd2, 8'd8},
        // R11: disable keeps pending stamp
        '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0000_0078, 32'h0000_0089, 1'b1, 32'h0000_0077, 32'h0000_0088, 1'b0, 4'd2, 8'd11},
        // R11: read discards stale stamp while disabled
        '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'h0000_0079, 32'h0000_008A, 1'b0, 32'h0000_0077, 32'h0000_0088, 1'b0, 4'd2, 8'd11},
        // R6: fresh capture after enabling
        '{1'b1,1'b1,1'b1,1'b0,1'b1, 32'h0000_0099, 32'h0000_00AA, 1'b1, 32'h0000_0099, 32'h0000_00AA, 1'b1, 4'd2, 8'd6},
        // R6: plain read clears
        '{1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0000_009A, 32'h0000_00AB, 1'b0, 32'h0000_0099, 32'h0000_00AA, 1'b0, 4'd2, 8'd6},
        // R6: read while not pending changes nothing
        '{1'b0,1'b0,1'b1,1'b1,1'b1, 32'h0000_009B, 32'h0000_00AC, 1'b0, 32'h0000_0099, 32'h0000_00AA, 1'b0, 4'd2, 8'd6}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic q, input logic en, input logic rh,
                         input logic ie, input logic [31:0] s, input logic [31:0] n);
        tx_evt = e; tx_ts_req = q; cap_en = en; rd_hi = rh; irq_en = ie;
        time_sec = s; time_ns = n;
    endtask

    task automatic step_check_all(input string tag, input logic v, input logic [31:0] hi,
                                  input logic [31:0] lo, input logic iq, input logic [3:0] dr);
        @(posedge clk); #1;
        chk({tag, " valid"}, 64'(cap_valid), 64'(v));
        chk({tag, " hi"},    64'(cap_hi),    64'(hi));
        chk({tag, " lo"},    64'(cap_lo),    64'(lo));
        chk({tag, " irq"},   64'(irq),       64'(iq));
        chk({tag, " drop"},  64'(drop_cnt),  64'(dr));
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 valid", 64'(cap_valid), 64'd0);
        chk("R1 irq",   64'(irq),       64'd0);
        chk("R1 drop",  64'(drop_cnt),  64'd0);
        chk("R1 words", {cap_hi, cap_lo}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].evt, VEC[i].req, VEC[i].en, VEC[i].rdh, VEC[i].ien, VEC[i].sec, VEC[i].ns);
            step_check_all($sformatf("R%0d row%0d", VEC[i].rq, i),
                           VEC[i].e_valid, VEC[i].e_hi, VEC[i].e_lo, VEC[i].e_irq, VEC[i].e_drop);
        end

        // R10: saturation of the drop counter (currently 2)
        drive(1, 1, 1, 0, 1, 32'h0000_1234, 32'h0000_5678);
        step_check_all("R10 take", 1'b1, 32'h0000_1234, 32'h0000_5678, 1'b1, 4'd2);
        for (int k = 0; k < 20; k++) begin
            drive(1, 1, 1, 0, 1, 32'hFFFF_0000 + 32'(k), 32'h0000_0100);
            @(posedge clk); #1; @(negedge clk);
        end
        drive(0, 0, 1, 0, 1, 32'h0, 32'h0);
        step_check_all("R10 sat", 1'b1, 32'h0000_1234, 32'h0000_5678, 1'b0, 4'd15);

        // R1: reset while a stamp is pending
        rst_n = 1'b0;
        @(posedge clk); #1; @(negedge clk);
        rst_n = 1'b1;
        chk("R1 re valid", 64'(cap_valid), 64'd0);
        chk("R1 re drop",  64'(drop_cnt),  64'd0);
        chk("R1 re words", {cap_hi, cap_lo}, 64'd0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule